// File: doc/BRIEF.md
# Per-Pin Interrupt Event Detector

This block watches a bank of general-purpose input pins and turns selected conditions on them into latched interrupt flags. Each pin has its own control word. Inside that word a four-bit trigger code selects one of five conditions, or no condition at all. The five conditions are low level, high level, rising edge, falling edge and either edge. The pins come from the pad ring asynchronously, so they pass through a two-flop synchronizer before any detection takes place.

A detected condition latches the pin's bit in a status word. Software clears a bit by writing 1 to it. A single interrupt line stays high while any status bit is set. In level modes the flag is set again on every cycle that the pin sits at the selected level, so a clear only takes effect once the level has gone away.

The register bus is a plain word-wide strobe interface. Writes take effect at the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`, and the block is always ready. No data stream passes through the block, so it has no valid/ready handshake. Offsets that are not decoded read as zero and ignore writes.

Top module: `pin_evt_top`

## Requirements
- R1: After reset, every status flag is 0, every control word reads 0 and `irq_o` is 0.
- R2: Pin n's control word sits at byte offset 4·n (n = 0..31). Only bits 19:16, the trigger code, are stored. A read returns the code in bits 19:16 and zeros elsewhere.
- R3: Code 0x9 (rising edge) sets the pin's flag. Let clock edge 1 be the first edge after the pin goes from 0 to 1. The flag is first visible after edge 3, and it is set once per transition.
- R4: Code 0xA (falling edge) sets the flag on a 1-to-0 transition, with the same three-edge latency as R3.
- R5: Code 0xB (either edge) sets the flag on transitions in both directions, with the same latency as R3.
- R6: Code 0x8 (low level) and code 0xC (high level) set the flag on every cycle that the synchronized pin is at the selected level. A clear written while that level persists leaves the flag at 1.
- R7: Code 0x0, and every code not listed in R3 to R6, never sets the flag, whatever the pin does.
- R8: The status word is at offset 0xA0, with bit n belonging to pin n. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. Writing 0xFFFFFFFF clears every flag that has no new detection in that cycle.
- R9: If a detection and a write-1 clear hit the same bit in the same cycle, the flag is 1 afterwards.
- R10: `irq_o` is 1 exactly when at least one status flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data at `bus_addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| irq_o | output | 1 | Combined interrupt, high while any flag is set |

## Verification
A fresh detection on a pin and a software write-1 clear of that same pin's flag can land in the same cycle. The bench provokes this in two ways. First, it holds a pin at its level-mode level while writing the clear. Second, it arranges for the second transition of an either-edge pin to reach the detector in exactly the cycle of the clear, while the flag from the first transition is still set. In both cases the flag must read 1 afterwards. Random stimulus mixes clears with sparse pin toggles and trigger-code changes. A cycle-level bench model then judges every status read against the expected value.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

  typedef enum logic [3:0] {
    TRIG_OFF  = 4'h0,
    TRIG_LOW  = 4'h8,
    TRIG_RISE = 4'h9,
    TRIG_FALL = 4'hA,
    TRIG_BOTH = 4'hB,
    TRIG_HIGH = 4'hC
  } trig_e;

  // Detection for one pin given its trigger code and the synchronized
  // value this cycle (cur) and last cycle (prev).
  function automatic logic trig_hit(input logic [3:0] code,
                                    input logic cur, input logic prev);
    case (code)
      TRIG_LOW:  return !cur;
      TRIG_HIGH: return cur;
      TRIG_RISE: return cur && !prev;
      TRIG_FALL: return !cur && prev;
      TRIG_BOTH: return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic trig_valid(input logic [3:0] code);
    return code inside {TRIG_LOW, TRIG_HIGH, TRIG_RISE, TRIG_FALL, TRIG_BOTH};
  endfunction

endpackage

// File: rtl/pin_evt_sync.sv
module pin_evt_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= chain[STAGES-1];
  end

  assign cur = chain[STAGES-1];
endmodule

// File: rtl/pin_evt_cell.sv
module pin_evt_cell
  import pin_evt_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_wcode,
  input  logic              cur,
  input  logic              prev,
  output logic [CODE_W-1:0] cfg_q,
  output logic              hit
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wcode;
  end

  assign hit = trig_hit(cfg_q, cur, prev);

  // R7: codes outside the listed set never produce a detection
  p_off_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_valid(cfg_q) |-> !hit);

  // R3: a rising-edge pin only fires when the synchronized level is high
  p_rise_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == TRIG_RISE && hit) |-> (cur && $past(cur) == prev));
endmodule

// File: rtl/pin_evt_flags.sv
module pin_evt_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flags
);
  // A new detection has priority over a clear of the same bit.
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | hit;
  end

  // R9: a bit detected in a cycle is set afterwards, clear or not
  p_hit_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(hit)) == $past(hit)));

  // R8: a cleared bit without a new detection goes to 0
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(clr & ~hit)) == '0));

  // R8: a flag only appears when a detection caused it
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(hit)) == '0));
endmodule

// File: rtl/pin_evt_top.sv
module pin_evt_top
  import pin_evt_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int CODE_W      = 4,
  parameter int CODE_LSB    = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] STAT_OFF = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic              irq_o
);
  localparam int IDX_W = $clog2(NPINS);

  logic [NPINS-1:0]  cur, prev, hit_vec, flags, clr;
  logic [CODE_W-1:0] cfg_arr [NPINS];
  logic              in_ctrl, at_stat;
  logic [IDX_W-1:0]  idx;

  assign idx     = bus_addr[IDX_W+1:2];
  assign in_ctrl = (bus_addr[ADDR_W-1:IDX_W+2] == '0) && (bus_addr[1:0] == 2'b00);
  assign at_stat = (bus_addr == STAT_OFF);
  assign clr     = (bus_we && at_stat) ? bus_wdata[NPINS-1:0] : '0;

  pin_evt_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .cur(cur), .prev(prev)
  );

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      pin_evt_cell #(.CODE_W(CODE_W)) u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (bus_we && in_ctrl && (idx == IDX_W'(p))),
        .cfg_wcode(bus_wdata[CODE_LSB +: CODE_W]),
        .cur      (cur[p]),
        .prev     (prev[p]),
        .cfg_q    (cfg_arr[p]),
        .hit      (hit_vec[p])
      );
    end
  endgenerate

  pin_evt_flags #(.W(NPINS)) u_flags (
    .clk(clk), .rst_n(rst_n), .hit(hit_vec), .clr(clr), .flags(flags)
  );

  always_comb begin
    bus_rdata = '0;
    if (at_stat)      bus_rdata[NPINS-1:0] = flags;
    else if (in_ctrl) bus_rdata[CODE_LSB +: CODE_W] = cfg_arr[idx];
  end

  assign irq_o = |flags;

  // R10: an idle interrupt line rises exactly when some pin was detected
  p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |=> (irq_o == ($past(hit_vec) != '0)));
endmodule

// File: tb/pin_evt_top_test.sv
module pin_evt_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [3:0]  m_cfg [32];
  logic [31:0] m_flag, m_s0, m_s1, m_prev;

  always #5 clk = ~clk;

  pin_evt_top uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .irq_o(irq_o)
  );

  function automatic logic exp_hit(input logic [3:0] c, input logic now, input logic old);
    if (c == 4'h8) return now == 1'b0;
    if (c == 4'hC) return now == 1'b1;
    if (c == 4'h9) return now && !old;
    if (c == 4'hA) return old && !now;
    if (c == 4'hB) return now != old;
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, advance the model at posedge.
  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d);
    logic [31:0] hits, clrm;
    bus_we = we; bus_addr = a; bus_wdata = d;
    hits = '0;
    for (int i = 0; i < 32; i++) hits[i] = exp_hit(m_cfg[i], m_s1[i], m_prev[i]);
    clrm = (we && a == 8'hA0) ? d : '0;
    @(posedge clk);
    m_flag = (m_flag & ~clrm) | hits;
    m_prev = m_s1; m_s1 = m_s0; m_s0 = pin_in;
    if (we && a < 8'h80 && a[1:0] == 2'b00) m_cfg[a[6:2]] = d[19:16];
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 32'h0);
  endtask

  task automatic chk_status(input string req);
    bus_addr = 8'hA0; #1;
    check(req, bus_rdata, m_flag);
    check({req, " irq"}, {31'h0, irq_o}, {31'h0, |m_flag});
  endtask

  task automatic chk_cfg(input string req, input int p);
    bus_addr = 8'(p * 4); #1;
    check(req, bus_rdata, {12'h0, m_cfg[p], 16'h0});
  endtask

  task automatic set_cfg(input int p, input logic [3:0] c);
    cyc(1'b1, 8'(p * 4), {12'h0, c, 16'h0});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] codes [9];
    void'($urandom(32'd4711));
    codes = '{4'h0, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'h3, 4'hF, 4'hD};
    rst_n = 1'b0; bus_we = 0; bus_addr = 0; bus_wdata = 0; pin_in = 0;
    for (int i = 0; i < 32; i++) m_cfg[i] = 4'h0;
    m_flag = 0; m_s0 = 0; m_s1 = 0; m_prev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_status("R1");
    chk_cfg("R1", 0); chk_cfg("R1", 31);

    // R2 only the code field is kept
    cyc(1'b1, 8'h1C, 32'hFFFF_FFFF);
    bus_addr = 8'h1C; #1; check("R2", bus_rdata, 32'h000F_0000);
    set_cfg(7, 4'h0);
    chk_cfg("R2", 7);

    // R3 rising edge latency on pin 3
    set_cfg(3, 4'h9);
    pin_in[3] = 1'b1;
    idle(2); chk_status("R3"); check("R3 not yet", bus_rdata[3], 1'b0);
    idle(1); chk_status("R3"); check("R3 set", bus_rdata[3], 1'b1);
    cyc(1'b1, 8'hA0, 32'h8); idle(3); check("R3 once", bus_rdata[3], 1'b0);

    // R4 falling edge on pin 3
    set_cfg(3, 4'hA);
    pin_in[3] = 1'b0; idle(3);
    chk_status("R4"); check("R4 set", bus_rdata[3], 1'b1);
    cyc(1'b1, 8'hA0, 32'hFFFF_FFFF); chk_status("R8");

    // R5 either edge on pin 4, then R9 priority with second edge
    set_cfg(4, 4'hB);
    pin_in[4] = 1'b1; idle(1);
    pin_in[4] = 1'b0; idle(2);
    chk_status("R5"); check("R5 rise", bus_rdata[4], 1'b1);
    cyc(1'b1, 8'hA0, 32'h10);   // fall reaches detector now
    chk_status("R9"); check("R9 hit wins", bus_rdata[4], 1'b1);
    cyc(1'b1, 8'hA0, 32'h10); chk_status("R8");

    // R8 writing zero leaves flags alone
    pin_in[4] = 1'b1; idle(3);
    cyc(1'b1, 8'hA0, 32'h0); chk_status("R8"); check("R8 zero write", bus_rdata[4], 1'b1);

    // R6 high level sticks through clears
    set_cfg(9, 4'hC);
    pin_in[9] = 1'b1; idle(3);
    cyc(1'b1, 8'hA0, 32'hFFFF_FFFF);
    chk_status("R6"); check("R6 level holds", bus_rdata[9], 1'b1);
    pin_in[9] = 1'b0; idle(3);
    cyc(1'b1, 8'hA0, 32'hFFFF_FFFF);
    chk_status("R6"); check("R6 released", bus_rdata[9], 1'b0);
    set_cfg(9, 4'h8); idle(1);
    chk_status("R6"); check("R6 low level", bus_rdata[9], 1'b1);
    set_cfg(9, 4'h0);
    cyc(1'b1, 8'hA0, 32'hFFFF_FFFF);

    // R7 undefined and off codes ignore toggles
    set_cfg(12, 4'h3); set_cfg(13, 4'h0);
    for (int k = 0; k < 6; k++) begin
      pin_in[12] = ~pin_in[12]; pin_in[13] = ~pin_in[13]; idle(2);
    end
    chk_status("R7"); check("R7 silent", {30'h0, bus_rdata[13:12]}, 32'h0);

    // random mix, R10 on every status check
    for (int n = 0; n < 3000; n++) begin
      int r;
      pin_in = pin_in ^ ($urandom & $urandom & $urandom);
      r = int'($urandom_range(0, 9));
      if (r < 2)
        set_cfg(int'($urandom_range(0, 31)), codes[$urandom_range(0, 8)]);
      else if (r < 4)
        cyc(1'b1, 8'hA0, (r == 2) ? 32'hFFFF_FFFF : $urandom);
      else
        idle(1);
      chk_status("R10");
      if (n % 16 == 0) chk_cfg("R2", int'($urandom_range(0, 31)));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule